// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a faster source clock. The divide ratio is an unsigned number with an 8-bit integer part and a 4-bit binary fraction. A phase accumulator spreads the fraction over successive output periods. Each period lasts either the integer count of source cycles or one cycle more, so the long-run average ratio equals the programmed value exactly. Inside each period, a rising position and a falling position shape the output waveform, which sets the duty cycle. A one-cycle tick marks the first cycle of every period and paces the downstream sync counters. An external polarity input inverts the generated clock.

Configuration arrives through a simple write port. `wr_sel` = 0 selects the divider word and `wr_sel` = 1 selects the edge word. Both words are first held as pending values. The period sequencer copies them into the active set only on the cycle that ends a period, so a write never cuts a period short.

The sequencer is a two-state machine. In state BYPASS the active ratio is exactly one with zero fraction. In state COUNT a position counter runs from 0 to the period length minus one. The END transition is taken on the last cycle of a period, and always in BYPASS. It loads the pending words and enters BYPASS when the pending ratio is unity, otherwise COUNT.

Top module: `pixclk_frac_div`

## Requirements
- R1: While `rst_n` is low, `pix_clk` and `pix_tick` are 0. The divider word resets to 0x010 (ratio one) and the edge word resets to 0, so the block leaves reset in bypass.
- R2: The divider word sits in `wr_data[11:0]`. Bits 11:4 are the integer part I and bits 3:0 are the fraction F. An integer field of 0 is treated as 1. Every period lasts I or I+1 source cycles.
- R3: Each period adds F to a 4-bit accumulator, and a carry out lengthens that period by one cycle. Any 16 consecutive periods under one word therefore total exactly 16*I+F cycles.
- R4: `pix_tick` is high in the first cycle of each period, and in that cycle only. The outputs are registered, so counter position k appears at the ports one cycle after the sequencer holds it.
- R5: The edge word holds the rise position in `wr_data[8:0]` and the fall position in `wr_data[24:16]`, both in half-cycle steps. The half-step bit 0 of each is dropped. With r = rise/2 and f = fall/2, `pix_clk` (before inversion) is high at positions r..f-1 when r<f, at positions >= r or < f when r>f, and never when r = f. Position 0 is the tick cycle.
- R6: Setting rise = 0 and fall = I gives a high phase of floor(I/2) cycles in each period.
- R7: A word written in the middle of a period does not change that period. It takes effect at the next period start.
- R8: When the active word has I = 1 (or 0) and F = 0, `pix_tick` is high on every cycle and `pix_clk` stays at its inactive level whatever the edge word holds.
- R9: `pix_pol` = 1 inverts `pix_clk`. The polarity is registered, so it takes effect one cycle after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 1 | 0 selects the divider word, 1 selects the edge word |
| wr_data | input | 32 | Write data |
| pix_pol | input | 1 | Output clock inversion |
| pix_clk | output | 1 | Generated pixel clock |
| pix_tick | output | 1 | One-cycle strobe at each period start |

## Verification
If the position counter or the accumulator holds a wrong value, the tick spacing shifts in the very next period. A stuck accumulator shows within one 16-period window as a wrong total cycle count. A badly loaded edge word changes the high-phase count of the first period that uses it. An early load of pending words shows as a shortened period, visible at the tick that follows the write. A reference model in the bench follows every cycle, so any of these faults is reported on the cycle it reaches the ports.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [0:0] {
        S_BYPASS = 1'b0,
        S_COUNT  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/pfd_cfg_regs.sv
module pfd_cfg_regs #(
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 4,
    parameter int POS_W    = 9,
    parameter int DATA_W   = 32,
    parameter int FALL_LSB = 16,
    parameter int RISE_LSB = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    load_i,
    output logic [INT_W+FRAC_W-1:0] pend_div_o,
    output logic [INT_W+FRAC_W-1:0] act_div_o,
    output logic [POS_W-2:0]        act_rise_o,
    output logic [POS_W-2:0]        act_fall_o
);
    localparam int DIV_W  = INT_W + FRAC_W;
    localparam int STEP_W = POS_W - 1;
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1) << FRAC_W;

    logic [STEP_W-1:0] pend_rise_q, pend_fall_q;
    logic              spare_unused;

    // half-step bits and spare bits carry no behaviour
    assign spare_unused = ^{wr_data[DATA_W-1:FALL_LSB+POS_W], wr_data[FALL_LSB],
                            wr_data[FALL_LSB-1:DIV_W]};

    // pending set: written at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_div_o  <= DIV_RST;
            pend_rise_q <= '0;
            pend_fall_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) begin
                pend_rise_q <= wr_data[RISE_LSB+1 +: STEP_W];
                pend_fall_q <= wr_data[FALL_LSB+1 +: STEP_W];
            end else begin
                pend_div_o <= wr_data[DIV_W-1:0];
            end
        end
    end

    // active set: copied only at a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_div_o  <= DIV_RST;
            act_rise_o <= '0;
            act_fall_o <= '0;
        end else if (load_i) begin
            act_div_o  <= pend_div_o;
            act_rise_o <= pend_rise_q;
            act_fall_o <= pend_fall_q;
        end
    end
endmodule

// File: rtl/pfd_period_seq.sv
module pfd_period_seq
    import pfd_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] pend_div_i,
    output logic                    load_o,
    output logic                    tick_o,
    output logic                    bypass_o,
    output logic [INT_W:0]          cnt_o,
    output seq_state_e              state_o
);
    localparam int CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(1) << INT_W;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, len_q, len_d;
    logic [FRAC_W-1:0] acc_q, acc_d, frac;
    logic [INT_W-1:0]  int_raw, int_eff;
    logic              carry, at_end, next_unity;

    assign int_raw    = pend_div_i[FRAC_W +: INT_W];
    assign frac       = pend_div_i[FRAC_W-1:0];
    assign int_eff    = (int_raw == '0) ? INT_W'(1) : int_raw;
    assign {carry, acc_d} = {1'b0, acc_q} + {1'b0, frac};
    assign len_d      = CNT_W'(int_eff) + CNT_W'(carry);
    assign next_unity = (int_eff == INT_W'(1)) && (frac == '0);

    // next-state logic: END transition picks BYPASS or COUNT
    always_comb begin
        state_d = state_q;
        at_end  = 1'b1;
        unique case (state_q)
            S_BYPASS: at_end = 1'b1;
            S_COUNT:  at_end = (cnt_q == len_q - CNT_W'(1));
            default:  at_end = 1'b1;
        endcase
        if (at_end) begin
            state_d = next_unity ? S_BYPASS : S_COUNT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= CNT_W'(1);
            acc_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
            len_q <= len_d;
            acc_q <= acc_d;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        load_o   = at_end;
        tick_o   = (cnt_q == '0);
        bypass_o = (state_q == S_BYPASS);
        cnt_o    = cnt_q;
        state_o  = state_q;
    end

    assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT) |-> (len_q >= CNT_W'(1) && len_q <= LEN_MAX));
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT) |-> (cnt_q < len_q));
endmodule

// File: rtl/pfd_edge_shaper.sv
module pfd_edge_shaper #(
    parameter int POS_W = 9,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    input  logic             bypass_i,
    input  logic [POS_W-2:0] rise_i,
    input  logic [POS_W-2:0] fall_i,
    input  logic             pol_i,
    output logic             pix_clk_o,
    output logic             pix_tick_o
);
    logic [CNT_W-1:0] rise_x, fall_x;
    logic             hi_c;

    assign rise_x = CNT_W'(rise_i);
    assign fall_x = CNT_W'(fall_i);

    always_comb begin
        if (bypass_i) begin
            hi_c = 1'b0;
        end else if (rise_x <= fall_x) begin
            hi_c = (cnt_i >= rise_x) && (cnt_i < fall_x);
        end else begin
            hi_c = (cnt_i >= rise_x) || (cnt_i < fall_x);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_clk_o  <= 1'b0;
            pix_tick_o <= 1'b0;
        end else begin
            pix_clk_o  <= hi_c ^ pol_i;
            pix_tick_o <= tick_i;
        end
    end

    assert_bypass_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> (pix_clk_o == $past(pol_i)));
    assert_bypass_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> pix_tick_o);
endmodule

// File: rtl/pixclk_frac_div.sv
module pixclk_frac_div
    import pfd_pkg::*;
#(
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 4,
    parameter int POS_W    = 9,
    parameter int DATA_W   = 32,
    parameter int FALL_LSB = 16,
    parameter int RISE_LSB = 0
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pix_pol,
    output logic              pix_clk,
    output logic              pix_tick
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int CNT_W = INT_W + 1;

    logic [DIV_W-1:0] pend_div, act_div;
    logic [POS_W-2:0] act_rise, act_fall;
    logic             load, tick, bypass;
    logic [CNT_W-1:0] cnt;
    seq_state_e       seq_state;

    pfd_cfg_regs #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .POS_W(POS_W),
        .DATA_W(DATA_W), .FALL_LSB(FALL_LSB), .RISE_LSB(RISE_LSB)
    ) u_cfg (
        .clk(clk_src), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load_i(load), .pend_div_o(pend_div),
        .act_div_o(act_div), .act_rise_o(act_rise), .act_fall_o(act_fall)
    );

    pfd_period_seq #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_seq (
        .clk(clk_src), .rst_n(rst_n), .pend_div_i(pend_div), .load_o(load),
        .tick_o(tick), .bypass_o(bypass), .cnt_o(cnt), .state_o(seq_state)
    );

    pfd_edge_shaper #(.POS_W(POS_W), .CNT_W(CNT_W)) u_shape (
        .clk(clk_src), .rst_n(rst_n), .cnt_i(cnt), .tick_i(tick),
        .bypass_i(bypass), .rise_i(act_rise), .fall_i(act_fall),
        .pol_i(pix_pol), .pix_clk_o(pix_clk), .pix_tick_o(pix_tick)
    );

    assert_swap_at_start_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
        (act_div != $past(act_div)) |-> (cnt == '0));
    assert_bypass_rule_R8: assert property (@(posedge clk_src) disable iff (!rst_n)
        (seq_state == S_BYPASS) |->
            (act_div[FRAC_W +: INT_W] <= INT_W'(1) && act_div[FRAC_W-1:0] == '0));
endmodule

// File: tb/pixclk_frac_div_tb.sv
module pixclk_frac_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pix_pol = 1'b0;
    logic        pix_clk, pix_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit stream_on = 1'b0;

    always #5 clk = ~clk;

    pixclk_frac_div u_dut (
        .clk_src(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pix_pol(pix_pol), .pix_clk(pix_clk), .pix_tick(pix_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    int         m_cnt, m_len, m_acc;
    bit         m_byp;
    logic [11:0] m_pdiv;
    logic [7:0]  m_prise, m_pfall, m_arise, m_afall;
    logic        exp_tick, exp_clk;

    function automatic bit model_hi(int c, bit byp, int r, int f);
        if (byp) return 1'b0;
        if (r <= f) return (c >= r) && (c < f);
        return (c >= r) || (c < f);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_len = 1; m_acc = 0; m_byp = 1'b1;
            m_pdiv = 12'h010; m_prise = 0; m_pfall = 0; m_arise = 0; m_afall = 0;
            exp_tick = 1'b0; exp_clk = 1'b0;
        end else begin
            int ip, fp, s;
            exp_tick = (m_cnt == 0);
            exp_clk  = model_hi(m_cnt, m_byp, m_arise, m_afall) ^ pix_pol;
            if (m_byp || m_cnt == m_len - 1) begin
                ip = m_pdiv[11:4]; if (ip == 0) ip = 1;
                fp = m_pdiv[3:0];
                s = m_acc + fp;
                m_len = ip + (s >= 16 ? 1 : 0);
                m_acc = s % 16;
                m_cnt = 0;
                m_byp = (ip == 1) && (fp == 0);
                m_arise = m_prise; m_afall = m_pfall;
            end else begin
                m_cnt++;
            end
            if (wr_en) begin
                if (wr_sel) begin
                    m_prise = wr_data[8:1];
                    m_pfall = wr_data[24:17];
                end else begin
                    m_pdiv = wr_data[11:0];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (stream_on && rst_n) begin
            check(pix_tick == exp_tick, "R4 stream tick", pix_tick, exp_tick);
            check(pix_clk == exp_clk, "R5 stream clk", pix_clk, exp_clk);
        end
    end

    task automatic write_reg(input bit sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!pix_tick);
    endtask

    task automatic settle();
        wait_tick();
        wait_tick();
    endtask

    // starts at a tick cycle; ends at the tick after nper periods
    task automatic measure(input int nper, output int cyc, output int hi, output int first);
        cyc = 0; hi = 0; first = pix_clk;
        for (int p = 0; p < nper; p++) begin
            do begin
                if (pix_clk) hi++;
                cyc++;
                @(negedge clk);
            end while (!pix_tick);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int cyc, hi, first, cnt;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(pix_tick == 1'b0, "R1 reset tick", pix_tick, 0);
        check(pix_clk == 1'b0, "R1 reset clk", pix_clk, 0);
        rst_n = 1'b1;
        stream_on = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(pix_tick == 1'b1, "R1 default bypass tick", pix_tick, 1);
            @(negedge clk);
        end

        // R2/R6: integer 5, 50% duty
        write_reg(0, 32'h050); write_reg(1, 32'd5 << 16); settle();
        measure(1, cyc, hi, first);
        check(cyc == 5, "R2 period", cyc, 5);
        check(hi == 2, "R6 duty", hi, 2);
        check(first == 1, "R5 rise at 0", first, 1);

        // R5 wrap: rise 6, fall 2 of 8
        write_reg(0, 32'h080); write_reg(1, (32'd4 << 16) | 32'd12); settle();
        measure(1, cyc, hi, first);
        check(hi == 4, "R5 wrap high", hi, 4);
        check(first == 1, "R5 wrap pos0", first, 1);

        // R5 equal positions
        write_reg(1, (32'd12 << 16) | 32'd12); settle();
        measure(1, cyc, hi, first);
        check(hi == 0, "R5 equal", hi, 0);

        // R5 half step dropped
        write_reg(0, 32'h060); write_reg(1, (32'd7 << 16) | 32'd1); settle();
        measure(1, cyc, hi, first);
        check(hi == 3, "R5 half step", hi, 3);

        // R3 fraction
        write_reg(0, 32'h073); write_reg(1, 32'd0); settle();
        measure(16, cyc, hi, first);
        check(cyc == 115, "R3 16 periods", cyc, 115);

        // R2 clamp with fraction
        write_reg(0, 32'h005); settle();
        measure(16, cyc, hi, first);
        check(cyc == 21, "R2 clamp frac", cyc, 21);

        // R2/R8 clamp to unity bypass, edges ignored
        write_reg(1, 32'd10 << 16); write_reg(0, 32'h000); settle();
        for (int k = 0; k < 5; k++) begin
            check(pix_tick == 1'b1, "R8 bypass tick", pix_tick, 1);
            check(pix_clk == 1'b0, "R8 bypass clk", pix_clk, 0);
            @(negedge clk);
        end

        // R9 polarity
        write_reg(0, 32'h060); write_reg(1, 32'd4 << 16); pix_pol = 1'b1; settle();
        measure(1, cyc, hi, first);
        check(hi == 4, "R9 inverted high", hi, 4);
        check(first == 0, "R9 inverted pos0", first, 0);
        pix_pol = 1'b0;

        // R7 mid-period write
        write_reg(0, 32'h140); write_reg(1, 32'd20 << 16); settle();
        cnt = 0;
        do begin
            cnt++;
            if (cnt == 5) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h030; end
            else wr_en = 1'b0;
            @(negedge clk);
        end while (!pix_tick);
        wr_en = 1'b0;
        check(cnt == 20, "R7 current period kept", cnt, 20);
        measure(1, cyc, hi, first);
        check(cyc == 3, "R7 next period new", cyc, 3);

        // random mix, checked by the stream model
        for (int it = 0; it < 40; it++) begin
            logic [31:0] d;
            d = {20'd0, 8'($urandom_range(0, 12)), ($urandom_range(0, 1) == 1) ? 4'($urandom) : 4'd0};
            write_reg(0, d);
            write_reg(1, (32'($urandom_range(0, 31)) << 16) | 32'($urandom_range(0, 31)));
            pix_pol = 1'($urandom);
            repeat ($urandom_range(3, 60)) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule